// File: doc/BRIEF.md
# Quad Serial Channel Address Decoder

This block sits between a 16-bit I/O address bus and four serial controller channels. Each channel has eight register locations. The block turns each bus access into one channel select, a 3-bit register offset and a card-claim signal. The card-claim signal tells the bus that this card owns the address.

A configuration input picks one of two decode schemes.

- **Discrete scheme:** each channel is placed at its own legacy serial slot, chosen by a 3-bit slot code. Every address bit is compared. The lower two channels cannot use the highest slot code, and the upper two channels cannot use the lowest one. A forbidden code leaves that channel unmapped.
- **Block scheme:** the four channels are packed in order into one 32-byte window aligned on a 32-byte boundary. A disabled channel still claims its eight addresses, so no other device can use them, but it is never selected.

The block is purely combinational, so its outputs follow the inputs within the same cycle.

Top module: `qsad_top`

## Requirements
- R1: `reg_ofs` always equals `io_addr[2:0]`, whether or not a strobe is active.
- R2: While neither `rd_stb` nor `wr_stb` is high, `chan_sel` is 0 and `card_claim` is 0.
- R3: In discrete mode (`mode_block`=0), slot codes 0 to 7 map to the bases 0x03F8, 0x02F8, 0x3220, 0x3228, 0x4220, 0x4228, 0x5220 and 0x5228. An enabled channel whose slot is valid is selected when `io_addr[15:3]` equals its base bits [15:3].
- R4: In discrete mode, code 7 is invalid for channels 0 and 1, and code 0 is invalid for channels 2 and 3. A channel with an invalid code is never selected and never claims.
- R5: In discrete mode, a channel whose `chan_en` bit is 0 is never selected and its slot produces no claim.
- R6: When two enabled discrete channels map to the same slot, only the lower-numbered channel is selected.
- R7: In block mode (`mode_block`=1), an access is inside the window when `io_addr[15:5]` equals `blk_base`. Inside the window, channel `io_addr[4:3]` is selected if its `chan_en` bit is 1.
- R8: In block mode, any access inside the window asserts `card_claim`, including an access to a disabled channel's eight addresses, which selects no channel.
- R9: At most one bit of `chan_sel` is ever high.
- R10: In block mode, an access outside the window gives no select and no claim.
- R11: In discrete mode, `card_claim` is high exactly when a channel is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_addr | input | 16 | I/O address of the current access |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| mode_block | input | 1 | 1 selects the block scheme, 0 the discrete scheme |
| slot_sel | input | 12 | Discrete slot code, 3 bits per channel; channel n uses bits [3n+2:3n] |
| blk_base | input | 11 | Block window base, compared with io_addr[15:5] |
| chan_en | input | 4 | Per-channel enable, bit n for channel n |
| chan_sel | output | 4 | One-hot channel select |
| reg_ofs | output | 3 | Register offset within the selected channel |
| card_claim | output | 1 | The card owns the current access |

## Verification
Assertions in the decoder check on every evaluation that:
- at most one channel is selected;
- nothing is driven without a strobe;
- a selected channel is always enabled and always claimed;
- in block mode the selected channel matches the address lane;
- in discrete mode the claim follows the selects.

Only the bench scenarios can show the rest:
- the slot table values;
- the forbidden codes for each channel pair;
- lower-channel priority when two channels share a slot;
- a disabled block channel still claiming its space;
- the window boundaries.

A full sweep of the address space in both modes covers these, with random enables and slot codes checked against a reference model.

// File: rtl/qsad_pkg.sv
// Package: shared sizes and the legacy slot table for the quad channel decoder.
// Assumes a 3-bit slot code and a 16-bit address space.
package qsad_pkg;
    localparam int ADDR_W = 16;
    localparam int SLOT_W = 3;
    localparam int NSLOT  = 1 << SLOT_W;

    // Legacy base address of each slot code.
    function automatic logic [ADDR_W-1:0] slot_base(input logic [SLOT_W-1:0] code);
        logic [ADDR_W-1:0] b;
        case (code)
            3'd0:    b = 16'h03F8;
            3'd1:    b = 16'h02F8;
            3'd2:    b = 16'h3220;
            3'd3:    b = 16'h3228;
            3'd4:    b = 16'h4220;
            3'd5:    b = 16'h4228;
            3'd6:    b = 16'h5220;
            default: b = 16'h5228;
        endcase
        return b;
    endfunction

    // Whether a slot code is legal for a channel: the lower half of the channels
    // lose the top code, the upper half lose code zero.
    function automatic logic slot_legal(input int ch, input int nch, input logic [SLOT_W-1:0] code);
        if (ch < nch / 2) return code != SLOT_W'(NSLOT - 1);
        else              return code != '0;
    endfunction
endpackage

// File: rtl/qsad_disc_match.sv
// Module: discrete-scheme match for one channel.
// Raises hit when the address falls in the eight registers at the channel's
// legacy slot, the slot code is legal for this channel and the channel is enabled.
// Assumes every slot base is 8-byte aligned.
module qsad_disc_match
    import qsad_pkg::*;
#(
    parameter int CH     = 0,
    parameter int NUM_CH = 4,
    parameter int REG_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SLOT_W-1:0] code,
    input  logic              en,
    output logic              hit
);
    logic [ADDR_W-1:0] base;

    // Compare the address against the chosen slot, ignoring the register offset bits.
    always_comb begin
        base = slot_base(code);
        hit  = en && slot_legal(CH, NUM_CH, code)
                  && (addr[ADDR_W-1:REG_W] == base[ADDR_W-1:REG_W]);
    end
endmodule

// File: rtl/qsad_blk_match.sv
// Module: block-scheme window decode.
// Raises win when the address lies in the aligned window, and drives one lane
// request per enabled channel, indexed by the address bits just above the offset.
// Assumes the window spans exactly NUM_CH * 2**REG_W bytes.
module qsad_blk_match
    import qsad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int REG_W  = 3
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [ADDR_W-REG_W-$clog2(NUM_CH)-1:0] base,
    input  logic [NUM_CH-1:0]       en,
    output logic                    win,
    output logic [NUM_CH-1:0]       lane_req
);
    localparam int LANE_W = $clog2(NUM_CH);
    localparam int WIN_W  = REG_W + LANE_W;

    logic [LANE_W-1:0] lane;

    // Window hit from the upper address bits.
    always_comb begin
        win  = (addr[ADDR_W-1:WIN_W] == base);
        lane = addr[WIN_W-1:REG_W];
    end

    // One request per lane, gated by the channel enable.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        assign lane_req[i] = win && en[i] && (lane == LANE_W'(i));
    end
endmodule

// File: rtl/qsad_prio.sv
// Module: fixed-priority picker, lowest index wins.
// Assumes any number of request bits may be high at once.
module qsad_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // Grant the lowest set request bit.
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) gnt = N'(1) << i;
        end
    end
endmodule

// File: rtl/qsad_top.sv
// Module: quad serial channel address decoder, top level.
// Combines the discrete and block decoders, applies the strobe gate, and
// produces one-hot selects, the register offset and the card claim.
// Assumes the strobes are already qualified by bus timing upstream.
module qsad_top
    import qsad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int REG_W  = 3
) (
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic                     rd_stb,
    input  logic                     wr_stb,
    input  logic                     mode_block,
    input  logic [NUM_CH*SLOT_W-1:0] slot_sel,
    input  logic [ADDR_W-REG_W-$clog2(NUM_CH)-1:0] blk_base,
    input  logic [NUM_CH-1:0]        chan_en,
    output logic [NUM_CH-1:0]        chan_sel,
    output logic [REG_W-1:0]         reg_ofs,
    output logic                     card_claim
);
    localparam int LANE_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0] disc_hit;
    logic [NUM_CH-1:0] disc_gnt;
    logic [NUM_CH-1:0] blk_req;
    logic              blk_win;
    logic              stb;

    // One discrete matcher per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_disc
        qsad_disc_match #(.CH(c), .NUM_CH(NUM_CH), .REG_W(REG_W)) u_match (
            .addr (io_addr),
            .code (slot_sel[c*SLOT_W +: SLOT_W]),
            .en   (chan_en[c]),
            .hit  (disc_hit[c])
        );
    end

    qsad_prio #(.N(NUM_CH)) u_prio (
        .req (disc_hit),
        .gnt (disc_gnt)
    );

    qsad_blk_match #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_blk (
        .addr     (io_addr),
        .base     (blk_base),
        .en       (chan_en),
        .win      (blk_win),
        .lane_req (blk_req)
    );

    // Pick the active scheme and gate everything with the strobes.
    always_comb begin
        stb     = rd_stb | wr_stb;
        reg_ofs = io_addr[REG_W-1:0];
        if (!stb) begin
            chan_sel   = '0;
            card_claim = 1'b0;
        end else if (mode_block) begin
            chan_sel   = blk_req;
            card_claim = blk_win;
        end else begin
            chan_sel   = disc_gnt;
            card_claim = |disc_hit;
        end
    end

    // Output properties checked on every evaluation.
    always_comb begin
        p_one_sel_r9: assert ($onehot0(chan_sel))
            else $error("R9: more than one select");
        p_idle_quiet_r2: assert (rd_stb || wr_stb || (chan_sel == '0 && !card_claim))
            else $error("R2: output without strobe");
        p_sel_claims_r11: assert (chan_sel == '0 || card_claim)
            else $error("R11: select without claim");
        p_sel_enabled_r5: assert ((chan_sel & ~chan_en) == '0)
            else $error("R5: disabled channel selected");
        p_blk_lane_r7: assert (!mode_block || chan_sel == '0
                               || chan_sel == (NUM_CH'(1) << io_addr[REG_W +: LANE_W]))
            else $error("R7: block select on wrong lane");
        p_disc_claim_r11: assert (mode_block || !stb || (card_claim == (chan_sel != '0)))
            else $error("R11: discrete claim disagrees with selects");
    end
endmodule

// File: tb/tb_qsad_top.sv
// Bench: directed scenarios, one task each, plus a full address sweep against a reference model.
module tb_qsad_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0, mode_block = 1'b0;
    logic [11:0] slot_sel = '0;
    logic [10:0] blk_base = '0;
    logic [3:0]  chan_en = '0;
    logic [3:0]  chan_sel;
    logic [2:0]  reg_ofs;
    logic        card_claim;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    qsad_top dut (.*);

    // Expected slot bases written from the requirement table.
    function automatic logic [15:0] exp_base(input int code);
        logic [15:0] t [8] = '{16'h03F8, 16'h02F8, 16'h3220, 16'h3228,
                               16'h4220, 16'h4228, 16'h5220, 16'h5228};
        return t[code];
    endfunction

    // Reference decode: returns {sel[3:0], claim}.
    function automatic logic [4:0] ref_dec();
        logic [3:0] s = '0;
        logic cl = 1'b0;
        if (rd_stb || wr_stb) begin
            if (mode_block) begin
                if (io_addr[15:5] == blk_base) begin
                    cl = 1'b1;
                    if (chan_en[io_addr[4:3]]) s[io_addr[4:3]] = 1'b1;
                end
            end else begin
                for (int c = 0; c < 4; c++) begin
                    int code = int'(slot_sel[c*3 +: 3]);
                    bit legal = (c < 2) ? (code != 7) : (code != 0);
                    if (s == '0 && chan_en[c] && legal
                        && io_addr[15:3] == exp_base(code)[15:3]) s[c] = 1'b1;
                end
                cl = (s != '0);
            end
        end
        return {s, cl};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, io_addr, act, exp);
        end
    endtask

    // Apply one access and check the outputs against the given expectation.
    task automatic access(input logic [15:0] a, input logic [3:0] es, input logic ec, input string req);
        io_addr = a; rd_stb = 1'b1; wr_stb = 1'b0;
        #2;
        chk({chan_sel, card_claim} == {es, ec}, req, {11'd0, chan_sel, card_claim}, {11'd0, es, ec});
        rd_stb = 1'b0;
        #1;
    endtask

    task automatic t_idle();
        mode_block = 1'b0; chan_en = 4'hF; slot_sel = {3'd3, 3'd2, 3'd1, 3'd0};
        io_addr = 16'h03F9; rd_stb = 1'b0; wr_stb = 1'b0;
        #2;
        chk(chan_sel == 4'd0 && !card_claim, "R2 idle discrete", {11'd0, chan_sel, card_claim}, 16'd0);
        mode_block = 1'b1; blk_base = 11'h020; io_addr = 16'h0408;
        #2;
        chk(chan_sel == 4'd0 && !card_claim, "R2 idle block", {11'd0, chan_sel, card_claim}, 16'd0);
        chk(reg_ofs == 3'd0, "R1 offset idle", {13'd0, reg_ofs}, 16'd0);
        io_addr = 16'h040F;
        #2;
        chk(reg_ofs == 3'd7, "R1 offset idle", {13'd0, reg_ofs}, 16'd7);
    endtask

    task automatic t_table();
        mode_block = 1'b0;
        for (int code = 0; code < 8; code++) begin
            for (int c = 0; c < 4; c++) begin
                bit legal = (c < 2) ? (code != 7) : (code != 0);
                chan_en = 4'b1 << c;
                slot_sel = '0;
                slot_sel[c*3 +: 3] = 3'(code);
                access(exp_base(code) + 16'd5, legal ? (4'b1 << c) : 4'd0, legal,
                       legal ? "R3 slot table" : "R4 forbidden code");
                chk(reg_ofs == 3'd5, "R1 offset", {13'd0, reg_ofs}, 16'd5);
            end
        end
    endtask

    task automatic t_disabled();
        mode_block = 1'b0; slot_sel = {3'd5, 3'd4, 3'd1, 3'd0};
        chan_en = 4'b1101;
        access(16'h02F8, 4'd0, 1'b0, "R5 disabled discrete");
        access(16'h03FF, 4'b0001, 1'b1, "R3 enabled neighbour");
    endtask

    task automatic t_priority();
        mode_block = 1'b0; chan_en = 4'hF;
        slot_sel = {3'd3, 3'd3, 3'd3, 3'd3};
        access(16'h3228, 4'b0001, 1'b1, "R6 shared slot low wins");
        chan_en = 4'b1100;
        access(16'h322A, 4'b0100, 1'b1, "R6 shared slot ch2");
        access(16'h3230, 4'd0, 1'b0, "R3 past slot end");
    endtask

    task automatic t_block();
        mode_block = 1'b1; blk_base = 11'h031; chan_en = 4'b1011;
        access(16'h0620, 4'b0001, 1'b1, "R7 lane 0");
        access(16'h062F, 4'b0010, 1'b1, "R7 lane 1");
        access(16'h0630, 4'd0, 1'b1, "R8 disabled lane claims");
        access(16'h063F, 4'b1000, 1'b1, "R7 lane 3 end");
        access(16'h061F, 4'd0, 1'b0, "R10 below window");
        access(16'h0640, 4'd0, 1'b0, "R10 above window");
        io_addr = 16'h0637; rd_stb = 1'b0; wr_stb = 1'b1;
        #2;
        chk(card_claim && chan_sel == 4'd0, "R8 write to disabled lane",
            {11'd0, chan_sel, card_claim}, 16'd1);
        wr_stb = 1'b0;
        #1;
    endtask

    task automatic t_sweep(input bit blk);
        mode_block = blk;
        for (int a = 0; a < 65536; a++) begin
            if (a % 4096 == 0) begin
                chan_en = 4'($urandom);
                slot_sel = 12'($urandom);
                blk_base = 11'(a >> 5) + 11'($urandom_range(0, 3));
            end
            io_addr = 16'(a);
            rd_stb = 1'($urandom); wr_stb = 1'($urandom);
            #1;
            begin
                logic [4:0] e = ref_dec();
                chk({chan_sel, card_claim} == e && reg_ofs == io_addr[2:0] && $onehot0(chan_sel),
                    blk ? "R7 R8 R9 R10 sweep block" : "R3 R4 R5 R6 R9 R11 sweep discrete",
                    {8'd0, reg_ofs, chan_sel, card_claim}, {8'd0, io_addr[2:0], e});
            end
        end
        rd_stb = 1'b0; wr_stb = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    total++; bad++;
                    $display("FAIL watchdog actual=hung expected=done");
                    $display("test done: total=%0d bad=%0d", total, bad);
                    $finish;
                end
            end
        join_none
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #3;
        t_idle();
        t_table();
        t_disabled();
        t_priority();
        t_block();
        t_sweep(1'b0);
        t_sweep(1'b1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule